// File: doc/BRIEF.md
# Column-Write Simple Dual-Port RAM

This block is a single-clock memory with one write port and one independent read port. Each stored word is split into equal-width columns. A write-enable vector carries one bit per column, so a single write can update any subset of the columns at the addressed location and leave the other columns as they were. This suits packed-field tables and byte-lane style updates, where a producer owns only part of each word.

The read port runs in one of two modes, chosen by a parameter. In the default mode the read is registered and data appears one cycle after the address. In the other mode the read is combinational and data follows the address in the same cycle. In both modes a read of the location being written in the same cycle returns the contents from before the write.

Every word starts at one parameterized initial value. Reset leaves the memory contents alone and only sets the registered read output.

Top module: `colwr_sdp_ram`

## Requirements
- R1: The column count equals the width of `wrEn`. Each column is DATA_W/COLS bits wide, and a configuration where DATA_W is not a multiple of COLS is rejected at elaboration. Enable bit c selects bits [c*COL_W+COL_W-1 : c*COL_W]. Column 0 holds the least significant bits. With DATA_W=16 and COLS=4, `wrEn`=4'b0100 writes bits [11:8].
- R2: A write updates only the columns whose `wrEn` bit is 1 at `wrAddr`. All other columns of that word, and every other word, keep their contents.
- R3: A cycle with `wrEn` all zero changes no stored word.
- R4: A write with `wrEn` all ones replaces the whole word with `wrData`.
- R5: With RD_MODE set to registered, `rdData` after a rising edge equals the word at the `rdAddr` sampled at that edge.
- R6: With RD_MODE set to combinational, `rdData` equals the word at the current `rdAddr` within the same cycle, with no register in the path.
- R7: When `rdAddr` equals `wrAddr` during a write, the read returns the word as it was before that write, in both read modes.
- R8: Every word holds INIT_VAL before its first write. Asserting reset does not change any stored word.
- R9: With RD_MODE set to registered, reset is synchronous and sets `rdData` to INIT_VAL. It stays there while `rstN` is low, whatever `rdAddr` is.
- R10: The two ports are independent. A write to one address and a read of another address in the same cycle returns the read address's current contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes and the registered read act on the rising edge |
| rstN | input | 1 | Active-low synchronous reset for the registered read output only |
| wrEn | input | COLS | Column mask; bit c enables column c |
| wrAddr | input | ADDR_W | Unsigned write address |
| wrData | input | DATA_W | Write word; only the enabled columns are used |
| rdAddr | input | ADDR_W | Unsigned read address |
| rdData | output | DATA_W | Read word, registered or combinational per RD_MODE |

## Verification
The bound checker checks four things on every cycle:
- `rdData` holds still across idle cycles at a fixed read address, in both modes.
- In registered mode, a read that collides with a write at the same address returns the unchanged old word.
- `rdData` leaves reset at the initial value.
- `rdData` never carries unknown bits.

Some behaviours only the bench scenarios can show, because they need the stored contents:
- which columns a given mask really touched;
- that a write to one column leaves its neighbours intact;
- that the memory survives a reset.

The bench shows these by sweeping all sixteen masks over every address, in both read modes, against a shadow model.

// File: rtl/colwr_pkg.sv
package colwr_pkg;

  // Read-port flavour selected at elaboration.
  typedef enum logic {
    RD_REGISTERED    = 1'b0,
    RD_COMBINATIONAL = 1'b1
  } rdMode_e;

  // Strobes from control to datapath.
  typedef struct packed {
    logic wrGo;     // some column is enabled this cycle
    logic rdLoad;   // capture the read word into the output register
    logic rdClear;  // force the output register to the initial value
  } colwrStrobe_t;

endpackage

// File: rtl/colwr_bank.sv
// One column of the memory: DEPTH entries of COL_W bits each.
module colwr_bank #(
  parameter int          COL_W    = 4,
  parameter int          ADDR_W   = 4,
  parameter logic [COL_W-1:0] INIT_COL = '0
) (
  input  logic              clk,
  input  logic              wrStb,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [COL_W-1:0]  wrCol,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [COL_W-1:0]  rdCol
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [COL_W-1:0] store [DEPTH];

  // Power-up contents; reset never touches the array.
  initial begin
    for (int i = 0; i < DEPTH; i++) store[i] = INIT_COL;
  end

  always_ff @(posedge clk) begin
    if (wrStb) store[wrAddr] <= wrCol;
  end

  // Old-data read: the nonblocking update lands after this value is used.
  assign rdCol = store[rdAddr];
endmodule

// File: rtl/colwr_ctrl.sv
// Turns the column mask and reset into datapath strobes.
module colwr_ctrl
  import colwr_pkg::*;
#(
  parameter int      COLS    = 4,
  parameter rdMode_e RD_MODE = RD_REGISTERED
) (
  input  logic            rstN,
  input  logic [COLS-1:0] wrEn,
  output colwrStrobe_t    strobe,
  output logic [COLS-1:0] colSel
);
  always_comb begin
    strobe.wrGo    = |wrEn;
    strobe.rdClear = ~rstN;
    strobe.rdLoad  = rstN && (RD_MODE == RD_REGISTERED);
    colSel         = wrEn;
  end
endmodule

// File: rtl/colwr_datapath.sv
// Column banks plus the read-side stage (registered or bypassed).
module colwr_datapath
  import colwr_pkg::*;
#(
  parameter int                DATA_W   = 16,
  parameter int                COLS     = 4,
  parameter int                ADDR_W   = 4,
  parameter rdMode_e           RD_MODE  = RD_REGISTERED,
  parameter logic [DATA_W-1:0] INIT_VAL = '0
) (
  input  logic              clk,
  input  colwrStrobe_t      strobe,
  input  logic [COLS-1:0]   colSel,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData
);
  localparam int COL_W = DATA_W / COLS;

  logic [DATA_W-1:0] rdWord;

  for (genvar c = 0; c < COLS; c++) begin : g_col
    logic colStb;
    assign colStb = strobe.wrGo & colSel[c];
    colwr_bank #(
      .COL_W   (COL_W),
      .ADDR_W  (ADDR_W),
      .INIT_COL(INIT_VAL[c*COL_W +: COL_W])
    ) u_bank (
      .clk   (clk),
      .wrStb (colStb),
      .wrAddr(wrAddr),
      .wrCol (wrData[c*COL_W +: COL_W]),
      .rdAddr(rdAddr),
      .rdCol (rdWord[c*COL_W +: COL_W])
    );
  end

  if (RD_MODE == RD_REGISTERED) begin : g_rdReg
    logic [DATA_W-1:0] rdHold;
    always_ff @(posedge clk) begin
      if (strobe.rdClear)     rdHold <= INIT_VAL;
      else if (strobe.rdLoad) rdHold <= rdWord;
    end
    assign rdData = rdHold;
  end else begin : g_rdComb
    logic unusedRdStrobes;
    assign unusedRdStrobes = strobe.rdClear ^ strobe.rdLoad;
    assign rdData = rdWord;
  end
endmodule

// File: rtl/colwr_sdp_ram.sv
// Column-write simple dual-port RAM, thin top.
module colwr_sdp_ram
  import colwr_pkg::*;
#(
  parameter int                DATA_W   = 16,
  parameter int                COLS     = 4,
  parameter int                ADDR_W   = 4,
  parameter rdMode_e           RD_MODE  = RD_REGISTERED,
  parameter logic [DATA_W-1:0] INIT_VAL = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [COLS-1:0]   wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData
);
  // R1: the word must split evenly into columns; the address range is bounded.
  if ((DATA_W % COLS) != 0) begin : g_badColumns
    $error("colwr_sdp_ram: DATA_W must be a multiple of COLS");
  end
  if (ADDR_W < 2 || ADDR_W > 31) begin : g_badAddr
    $error("colwr_sdp_ram: ADDR_W must lie in 2..31");
  end

  colwrStrobe_t    strobe;
  logic [COLS-1:0] colSel;

  colwr_ctrl #(
    .COLS   (COLS),
    .RD_MODE(RD_MODE)
  ) u_ctrl (
    .rstN  (rstN),
    .wrEn  (wrEn),
    .strobe(strobe),
    .colSel(colSel)
  );

  colwr_datapath #(
    .DATA_W  (DATA_W),
    .COLS    (COLS),
    .ADDR_W  (ADDR_W),
    .RD_MODE (RD_MODE),
    .INIT_VAL(INIT_VAL)
  ) u_dp (
    .clk   (clk),
    .strobe(strobe),
    .colSel(colSel),
    .wrAddr(wrAddr),
    .wrData(wrData),
    .rdAddr(rdAddr),
    .rdData(rdData)
  );
endmodule

// File: rtl/colwr_sdp_ram_chk.sv
// Port-level checker bound to every colwr_sdp_ram instance.
module colwr_sdp_ram_chk
  import colwr_pkg::*;
#(
  parameter int                DATA_W   = 16,
  parameter int                COLS     = 4,
  parameter int                ADDR_W   = 4,
  parameter rdMode_e           RD_MODE  = RD_REGISTERED,
  parameter logic [DATA_W-1:0] INIT_VAL = '0
) (
  input logic              clk,
  input logic              rstN,
  input logic [COLS-1:0]   wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [DATA_W-1:0] wrData,
  input logic [ADDR_W-1:0] rdAddr,
  input logic [DATA_W-1:0] rdData
);
  logic sawReset = 1'b0;
  always_ff @(posedge clk) if (!rstN) sawReset <= 1'b1;

  logic unusedChk;
  assign unusedChk = ^wrData;

  // R8: read data is never unknown once reset has been seen
  assert_rd_known_R8: assert property (@(posedge clk) disable iff (!rstN)
    sawReset |-> !$isunknown(rdData));

  if (RD_MODE == RD_REGISTERED) begin : g_regChecks
    // R9: leaving reset, the output holds the initial value
    assert_rst_init_R9: assert property (@(posedge clk)
      ($rose(rstN) && sawReset) |-> (rdData == INIT_VAL));

    // R3 (R5 timing): idle cycles at a fixed address keep the output still
    assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
      (sawReset && $past(rstN) && wrEn == '0 && $past(wrEn) == '0 && $stable(rdAddr))
      |=> $stable(rdData));

    // R7: a colliding read returns the word from before the write
    assert_rdw_old_R7: assert property (@(posedge clk) disable iff (!rstN)
      (sawReset && $past(rstN) && wrEn != '0 && rdAddr == wrAddr &&
       $past(wrEn) == '0 && $stable(rdAddr))
      |=> $stable(rdData));
  end else begin : g_combChecks
    // R6: combinational read depends only on address and stored contents
    assert_async_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
      (sawReset && $stable(rdAddr) && $past(wrEn) == '0) |-> $stable(rdData));
  end
endmodule

bind colwr_sdp_ram colwr_sdp_ram_chk #(
  .DATA_W  (DATA_W),
  .COLS    (COLS),
  .ADDR_W  (ADDR_W),
  .RD_MODE (RD_MODE),
  .INIT_VAL(INIT_VAL)
) u_chk (.*);

// File: tb/colwr_sdp_ram_tb.sv
module colwr_sdp_ram_tb;
  import colwr_pkg::*;

  localparam int          DW   = 16;
  localparam int          NC   = 4;
  localparam int          AW   = 4;
  localparam int          NW   = 1 << AW;
  localparam logic [15:0] INIT = 16'hA5C3;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [NC-1:0] wrEn = '0;
  logic [AW-1:0] wrAddr = '0;
  logic [DW-1:0] wrData = '0;
  logic [AW-1:0] rdAddr = '0;
  logic [DW-1:0] rdReg, rdComb;

  always #5 clk = ~clk;

  colwr_sdp_ram #(.DATA_W(DW), .COLS(NC), .ADDR_W(AW),
    .RD_MODE(RD_REGISTERED), .INIT_VAL(INIT)) u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .rdAddr(rdAddr), .rdData(rdReg));

  colwr_sdp_ram #(.DATA_W(DW), .COLS(NC), .ADDR_W(AW),
    .RD_MODE(RD_COMBINATIONAL), .INIT_VAL(INIT)) u_dutComb (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .rdAddr(rdAddr), .rdData(rdComb));

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  logic [DW-1:0] model [NW];

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Called at a falling edge; returns at the next falling edge.
  task automatic step(input logic [NC-1:0] m, input logic [AW-1:0] wa,
                      input logic [DW-1:0] wd, input logic [AW-1:0] ra, input string tag);
    logic [DW-1:0] expOld;
    wrEn = m; wrAddr = wa; wrData = wd; rdAddr = ra;
    #1;
    chk({"R6 ", tag}, rdComb, model[ra]);
    expOld = model[ra];
    for (int c = 0; c < NC; c++)
      if (m[c]) model[wa][c*4 +: 4] = wd[c*4 +: 4];
    @(negedge clk);
    chk({"R5 ", tag}, rdReg, expOld);
  endtask

  initial begin
    for (int i = 0; i < NW; i++) model[i] = INIT;
    repeat (3) @(negedge clk);
    chk("R9 reset output", rdReg, INIT);
    rstN = 1'b1;

    // R8: initial contents everywhere
    for (int a = 0; a < NW; a++) step(4'b0000, 4'(a), 16'h0, 4'(a), "R8 init");

    // R1: explicit column position
    step(4'b1111, 4'd5, 16'h0000, 4'd0, "R4 clear");
    step(4'b0100, 4'd5, 16'hFFFF, 4'd0, "R1 setup");
    step(4'b0000, 4'd0, 16'h0000, 4'd5, "R1 column2");
    chk("R1 bits11to8", rdReg, 16'h0F00);

    // Exhaustive masks x addresses: collision read, then plain read
    for (int a = 0; a < NW; a++) begin
      for (int m = 0; m < 16; m++) begin
        logic [DW-1:0] wd;
        string tg;
        wd = {4'(a), 4'(m), 4'(a) ^ 4'h9, 4'(m) ^ 4'h6} ^ 16'(a * 16'h1357);
        tg = (m == 0) ? "R3" : (m == 15) ? "R4" : "R2";
        step(4'(m), 4'(a), wd, 4'(a), {"R7 ", tg});
        step(4'b0000, 4'(a), 16'hFFFF, 4'(a), tg);
      end
    end

    // R10: write one address while reading another
    for (int a = 0; a < NW; a++)
      step(4'(a), 4'(a), 16'(a * 16'h0F1D), 4'((a + 7) % NW), "R10");

    // R9 + R8: reset holds the output and keeps memory
    wrEn = '0; rdAddr = 4'd3; rstN = 1'b0;
    repeat (2) @(negedge clk);
    chk("R9 reset during run", rdReg, INIT);
    rstN = 1'b1;
    for (int a = 0; a < NW; a++) step(4'b0000, 4'(a), 16'h0, 4'(a), "R8 after reset");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule